// File: doc/BRIEF.md
# Interleaved Sampling Phase Sequencer

This block produces the sampling enables for a bank of interleaved converter channels running off one master clock. A single token circulates through a ring of flops, one stage per channel, so each channel's enable is high for exactly one master cycle in every lap of the ring. Alongside the ring, a small scheduler on the same clock drives a set of auxiliary enables: one for a reference channel and two for dummy channels. In every master cycle exactly one auxiliary enable is high, so the analog input always sees one interleaved channel plus one auxiliary channel as its load.

The reference samples once every `NUM_CH + 1` enabled cycles. Because the ring length is `NUM_CH`, each reference sample lands on the next channel in turn, and one tour of `NUM_CH` reference samples pairs the reference with every channel exactly once. The index of the channel currently paired with the reference is exported for the calibration logic, which compares the two conversions of the same input sample. Between reference samples, the two dummies take the auxiliary slot alternately while the reference converts.

The ring also checks its own contents in every cycle. If it ever holds no token or more than one, the ring is reseeded at stage 0 and the scheduler restarts its frame with it. Deasserting the enable freezes the whole schedule.

Top module: `phase_sequencer`

## Requirements
- R1: While reset is asserted (active-low `rst_n`), and in the first state after it, `ch_phase` equals 1 (only bit 0 set), `ref_phase` is 1, `dummy_phase` is 0 and `pair_idx` is 0.
- R2: On each clock edge with `en` high, the token in `ch_phase` moves from bit i to bit i+1, and from bit `NUM_CH-1` back to bit 0. Exactly one bit of `ch_phase` is high at all times.
- R3: On a clock edge with `en` low, `ch_phase`, `ref_phase`, `dummy_phase` and `pair_idx` keep their values.
- R4: `ref_phase` is high in the reset state and then again every `NUM_CH+1` enabled cycles, and low in all other states.
- R5: When `ref_phase` is high, bit `pair_idx` of `ch_phase` is high. `pair_idx` increases by one, modulo `NUM_CH`, each time `ref_phase` rises again, and holds its value between reference samples.
- R6: Over the first `NUM_CH` reference samples after reset, every channel index 0 to `NUM_CH-1` appears as `pair_idx` exactly once.
- R7: In every state, exactly one of `ref_phase`, `dummy_phase[0]` and `dummy_phase[1]` is high.
- R8: In the k-th state after a reference state (k = 1 to `NUM_CH`), `dummy_phase` is 2'b01 when k is odd and 2'b10 when k is even, so each dummy is used `NUM_CH/2` times per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance the schedule by one cycle when high |
| ch_phase | output | NUM_CH | One-hot sampling enables of the interleaved channels |
| ref_phase | output | 1 | Sampling enable of the reference channel |
| dummy_phase | output | 2 | Sampling enables of the two dummy channels |
| pair_idx | output | $clog2(NUM_CH) | Channel paired with the latest reference sample |

## Verification
The bench builds the block with the default `NUM_CH = 24`. This gives a 25-cycle reference frame, so one complete pairing tour takes 600 enabled cycles. The run therefore covers the full set of pairings, the ring wrap from stage 23 to stage 0, and the frame wrap in the same place where the pair index rolls from 23 back to 0. Freeze cycles are mixed in at several phases of the frame, and a reset is applied in the middle of a frame, to show that holding and restarting do not disturb the alignment between the ring and the scheduler.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

    typedef enum logic [1:0] {
        AUX_REF  = 2'd0,
        AUX_DUM0 = 2'd1,
        AUX_DUM1 = 2'd2
    } aux_slot_e;

    // {dummy1, dummy0, ref}
    function automatic logic [2:0] aux_decode(aux_slot_e slot);
        logic [2:0] v;
        case (slot)
            AUX_REF:  v = 3'b001;
            AUX_DUM0: v = 3'b010;
            AUX_DUM1: v = 3'b100;
            default:  v = 3'b001;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/phase_ring.sv
module phase_ring #(
    parameter int NUM_CH = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [NUM_CH-1:0] ring,
    output logic              resync
);

    localparam logic [NUM_CH-1:0] SEED = {{(NUM_CH-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [NUM_CH-1:0] ring;
    } ring_state_t;

    ring_state_t st_q, st_d;
    logic        legal;
    logic [NUM_CH-1:0] rotated;

    // rotate by one stage toward the top
    for (genvar i = 0; i < NUM_CH; i++) begin : g_rot
        if (i == 0) begin : g_wrap
            assign rotated[i] = st_q.ring[NUM_CH-1];
        end else begin : g_step
            assign rotated[i] = st_q.ring[i-1];
        end
    end

    always_comb begin
        st_d   = st_q;
        legal  = (st_q.ring != '0) && ((st_q.ring & (st_q.ring - 1'b1)) == '0);
        resync = !legal;
        if (!legal) begin
            st_d.ring = SEED;
        end else if (en) begin
            st_d.ring = rotated;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ring <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign ring = st_q.ring;

endmodule

// File: rtl/aux_scheduler.sv
module aux_scheduler
    import phase_seq_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int IDX_W = $clog2(NUM_CH),
    localparam int FR_W  = $clog2(NUM_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             resync,
    output logic             ref_phase,
    output logic [1:0]       dummy_phase,
    output logic [IDX_W-1:0] pair_idx
);

    localparam logic [FR_W-1:0]  FRAME_LAST = FR_W'(NUM_CH);
    localparam logic [IDX_W-1:0] PAIR_LAST  = IDX_W'(NUM_CH - 1);

    typedef struct packed {
        logic [FR_W-1:0]  frame;
        aux_slot_e        slot;
        logic [IDX_W-1:0] pair;
    } sched_state_t;

    localparam sched_state_t INIT = '{frame: '0, slot: AUX_REF, pair: '0};

    sched_state_t st_q, st_d;
    logic [2:0]   aux_vec;

    always_comb begin
        st_d = st_q;
        if (resync) begin
            st_d = INIT;
        end else if (en) begin
            st_d.frame = (st_q.frame == FRAME_LAST) ? '0 : st_q.frame + 1'b1;
            if (st_d.frame == '0) begin
                st_d.slot = AUX_REF;
                st_d.pair = (st_q.pair == PAIR_LAST) ? '0 : st_q.pair + 1'b1;
            end else if (st_d.frame[0]) begin
                st_d.slot = AUX_DUM0;
            end else begin
                st_d.slot = AUX_DUM1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign aux_vec     = aux_decode(st_q.slot);
    assign ref_phase   = aux_vec[0];
    assign dummy_phase = aux_vec[2:1];
    assign pair_idx    = st_q.pair;

endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer #(
    parameter int NUM_CH = 24,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [NUM_CH-1:0] ch_phase,
    output logic              ref_phase,
    output logic [1:0]        dummy_phase,
    output logic [IDX_W-1:0]  pair_idx
);

    logic resync;

    phase_ring #(.NUM_CH(NUM_CH)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .ring   (ch_phase),
        .resync (resync)
    );

    aux_scheduler #(.NUM_CH(NUM_CH)) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .resync      (resync),
        .ref_phase   (ref_phase),
        .dummy_phase (dummy_phase),
        .pair_idx    (pair_idx)
    );

endmodule

// File: rtl/phase_sequencer_chk.sv
module phase_sequencer_chk #(
    parameter int NUM_CH = 24,
    localparam int IDX_W = $clog2(NUM_CH),
    localparam int GAP_W = $clog2(NUM_CH + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [NUM_CH-1:0] ch_phase,
    input logic              ref_phase,
    input logic [1:0]        dummy_phase,
    input logic [IDX_W-1:0]  pair_idx
);

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (en) begin
            gap_q <= ref_phase ? GAP_W'(1) : gap_q + 1'b1;
        end
    end

    p_token_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ch_phase) == 1);

    p_token_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ch_phase == {$past(ch_phase[NUM_CH-2:0]), $past(ch_phase[NUM_CH-1])});

    p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ch_phase) && $stable(ref_phase) && $stable(dummy_phase) && $stable(pair_idx));

    p_ref_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_phase |-> (gap_q == '0) || (gap_q == GAP_W'(NUM_CH + 1)));

    p_ref_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_phase |-> ch_phase[pair_idx]);

    p_pair_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_phase |-> $stable(pair_idx));

    p_aux_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ref_phase, dummy_phase}) == 1);

    p_dummy_after_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en && ref_phase |=> dummy_phase == 2'b01);

    p_dummy_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en && dummy_phase[0] |=> dummy_phase == 2'b10);

endmodule

bind phase_sequencer phase_sequencer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .ch_phase    (ch_phase),
    .ref_phase   (ref_phase),
    .dummy_phase (dummy_phase),
    .pair_idx    (pair_idx)
);

// File: tb/tb_phase_sequencer.sv
`timescale 1ns/1ps
module tb_phase_sequencer;

    localparam int NUM_CH = 24;
    localparam int IDX_W  = $clog2(NUM_CH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [NUM_CH-1:0] ch_phase;
    logic              ref_phase;
    logic [1:0]        dummy_phase;
    logic [IDX_W-1:0]  pair_idx;

    always #10 clk = ~clk;

    phase_sequencer #(.NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .ch_phase(ch_phase),
        .ref_phase(ref_phase), .dummy_phase(dummy_phase), .pair_idx(pair_idx)
    );

    typedef struct packed {
        logic [NUM_CH-1:0] ch;
        logic              rf;
        logic [1:0]        dm;
        logic [IDX_W-1:0]  pr;
        logic              hold;
        logic              rst;
    } exp_t;

    exp_t sbq[$];
    exp_t mx;
    int   n_tests = 0;
    int   n_fail  = 0;
    int   m_pos, m_frame, m_pair;
    int   tour_cnt = 0;
    int   seen[NUM_CH];

    task automatic check(bit ok, string req, string what, int got, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic exp_t model_out(bit hold, bit rst);
        exp_t e;
        e.ch   = NUM_CH'(1) << m_pos;
        e.rf   = (m_frame == 0);
        e.dm   = (m_frame == 0) ? 2'b00 : ((m_frame % 2 == 1) ? 2'b01 : 2'b10);
        e.pr   = IDX_W'(m_pair);
        e.hold = hold;
        e.rst  = rst;
        return e;
    endfunction

    task automatic drive(bit e);
        @(negedge clk);
        en = e;
        if (e) begin
            m_pos   = (m_pos + 1) % NUM_CH;
            m_frame = (m_frame + 1) % (NUM_CH + 1);
            if (m_frame == 0) m_pair = (m_pair + 1) % NUM_CH;
        end
        sbq.push_back(model_out(!e, 1'b0));
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b0;
        m_pos = 0; m_frame = 0; m_pair = 0;
        sbq.push_back(model_out(1'b0, 1'b1));
        @(negedge clk);
        rst_n = 1'b1;
        sbq.push_back(model_out(1'b1, 1'b1));
    endtask

    // monitor: pop one expected item per clock and compare
    always @(posedge clk) begin
        #2;
        if (sbq.size() > 0) begin
            mx = sbq.pop_front();
            check(ch_phase == mx.ch, mx.rst ? "R1" : (mx.hold ? "R3" : "R2"),
                  "ch_phase", int'(ch_phase), int'(mx.ch));
            check(ref_phase == mx.rf, mx.rst ? "R1" : (mx.hold ? "R3" : "R4"),
                  "ref_phase", int'(ref_phase), int'(mx.rf));
            check(pair_idx == mx.pr, mx.rst ? "R1" : "R5",
                  "pair_idx", int'(pair_idx), int'(mx.pr));
            check(dummy_phase == mx.dm, mx.rst ? "R1" : "R8",
                  "dummy_phase", int'(dummy_phase), int'(mx.dm));
            check($countones({ref_phase, dummy_phase}) == 1, "R7",
                  "aux one-hot count", $countones({ref_phase, dummy_phase}), 1);
            if (ref_phase) begin
                check(ch_phase[pair_idx] == 1'b1, "R5", "paired channel bit",
                      int'(ch_phase[pair_idx]), 1);
                if ((mx.rst && !mx.hold || !mx.hold) && tour_cnt < NUM_CH) begin
                    seen[pair_idx]++;
                    tour_cnt++;
                end
            end
        end
    end

    initial begin
        #(20ns * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_CH; i++) seen[i] = 0;
        apply_reset();
        for (int i = 0; i < 30; i++) drive(1'b1);
        for (int i = 0; i < 10; i++) drive(1'b0);
        for (int i = 0; i < 50; i++) drive(i % 3 != 0);
        for (int i = 0; i < 700; i++) drive(1'b1);
        for (int i = 0; i < 13; i++) drive(1'b1);
        apply_reset();
        for (int i = 0; i < 40; i++) drive(i % 4 != 2);
        @(negedge clk);
        @(negedge clk);
        // R6: one full tour visits every channel once
        check(tour_cnt == NUM_CH, "R6", "reference samples in tour", tour_cnt, NUM_CH);
        for (int i = 0; i < NUM_CH; i++)
            check(seen[i] == 1, "R6", $sformatf("pairings of channel %0d", i), seen[i], 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule